// File: doc/BRIEF.md
# Conditional Trap Evaluator

This block decides whether a conditional trap instruction takes effect. It compares a first 32-bit operand with a second operand. In the register form the second operand is a 32-bit register value. In the immediate form it is a 16-bit immediate, sign-extended to 32 bits. Five relations are computed in parallel: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A 5-bit condition mask chooses which of them count. If any chosen relation holds, the block raises a trap request.

The pipeline that issues the instruction pulses `valid_i` for one cycle with the operands, form select and mask. One clock later `trap_o` carries the decision, and `reason_o` carries the program-exception reason code for a trap. Exception vectoring and state save happen elsewhere.

Top module: `trapcond_top`

## Requirements
- R1: Mask bit 4 (value 0x10) selects signed less-than: operand A below operand B in two's complement.
- R2: Mask bit 3 (value 0x08) selects signed greater-than.
- R3: Mask bit 2 (value 0x04) selects equality of the two 32-bit operands.
- R4: Mask bit 1 (value 0x02) selects unsigned less-than, and mask bit 0 (value 0x01) selects unsigned greater-than.
- R5: A trap is requested when at least one selected relation is true, and only then.
- R6: When `use_imm_i` is 1, operand B is `imm_i` sign-extended to 32 bits. The same extended value is used in the signed relations and, read as an unsigned 32-bit number, in the unsigned relations.
- R7: A mask of 0x00 never traps. A mask of 0x1F always traps.
- R8: The decision for inputs sampled at a rising edge with `valid_i` high appears on `trap_o` during the following cycle only. While `trap_o` is 1, `reason_o` equals the trap reason code (default 2). Otherwise `reason_o` is 0.
- R9: An edge with `valid_i` low gives `trap_o` = 0 in the next cycle. An edge with `rst_n` low clears `trap_o` and `reason_o`, whatever the other inputs are.
- R10: The operand that the selected form does not use has no effect on the outcome: `imm_i` in the register form, `opb_i` in the immediate form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Evaluate the presented operands this cycle |
| use_imm_i | input | 1 | 1 = immediate form, 0 = register form |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B, register form |
| imm_i | input | 16 | Signed immediate, immediate form |
| cond_mask_i | input | 5 | Relation selector, bit 4 down to bit 0: slt, sgt, eq, ult, ugt |
| trap_o | output | 1 | Trap request, one cycle per valid evaluation that hits |
| reason_o | output | 4 | Program-exception reason code, valid with trap_o |

## Verification
The hardest cases to reach are those where the signed and unsigned orderings disagree, that is, when exactly one operand has bit 31 set. Equality is also hard to reach, because two random 32-bit words almost never match. In the immediate form, an immediate is needed whose extension fills the upper half with ones. The random stimulus handles this in three ways. It often builds operand B from operand A by a small offset or a sign-bit flip. It draws immediates from both halves of the 16-bit range. It also sets operand A equal to the extended immediate. Directed cases then pin the 0x80000000 and 0xFFFFFFFF extremes with single-bit masks, so each relation is seen to fire or stay low on its own.

// File: rtl/trapcond_pkg.sv
// trapcond_pkg: shared types and constants of the trap evaluator.
// Assumes the mask bit order slt, sgt, eq, ult, ugt from bit 4 down to 0.
package trapcond_pkg;

    localparam int unsigned REL_COUNT = 5;

    localparam int unsigned BIT_SLT = 4;
    localparam int unsigned BIT_SGT = 3;
    localparam int unsigned BIT_EQ  = 2;
    localparam int unsigned BIT_ULT = 1;
    localparam int unsigned BIT_UGT = 0;

    // Relation vector; packed order matches the condition mask bit order.
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_vec_t;

endpackage

// File: rtl/trapcond_operand_sel.sv
// trapcond_operand_sel: picks operand B, either the register value or
// the sign-extended immediate. Assumes IMM_W <= DATA_W.
module trapcond_operand_sel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int unsigned EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // Replicate the immediate sign bit across the upper part.
    generate
        if (EXT_W == 0) begin : g_no_ext
            always_comb imm_ext = imm_val;
        end else begin : g_ext
            always_comb imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        end
    endgenerate

    // Form select between register and extended immediate.
    always_comb opnd_b = use_imm ? imm_ext : reg_val;

endmodule

// File: rtl/trapcond_relations.sv
// trapcond_relations: evaluates the five signed and unsigned relations
// between A and B. SHARED_CMP=1 derives the signed relations from one
// unsigned comparator plus sign bits; SHARED_CMP=0 uses separate signed
// comparators. Both variants give identical results.
module trapcond_relations
    import trapcond_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter bit          SHARED_CMP = 1'b1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output rel_vec_t          rel
);

    localparam int unsigned MSB = DATA_W - 1;

    logic eq_w;
    logic ult_w;
    logic ugt_w;
    logic slt_w;
    logic sgt_w;

    // Unsigned relations and equality, common to both variants.
    always_comb begin
        eq_w  = (a == b);
        ult_w = (a < b);
        ugt_w = !ult_w && !eq_w;
    end

    generate
        if (SHARED_CMP) begin : g_shared
            logic sign_diff;
            // Signs differ: the negative operand is smaller; else unsigned order.
            always_comb begin
                sign_diff = a[MSB] ^ b[MSB];
                slt_w     = sign_diff ? a[MSB] : ult_w;
                sgt_w     = sign_diff ? b[MSB] : ugt_w;
            end
        end else begin : g_separate
            // Dedicated two's complement comparators.
            always_comb begin
                slt_w = ($signed(a) < $signed(b));
                sgt_w = ($signed(a) > $signed(b));
            end
        end
    endgenerate

    // Pack into the mask-ordered relation vector.
    always_comb begin
        rel.slt = slt_w;
        rel.sgt = sgt_w;
        rel.eq  = eq_w;
        rel.ult = ult_w;
        rel.ugt = ugt_w;
    end

endmodule

// File: rtl/trapcond_decide.sv
// trapcond_decide: ANDs each relation with its mask bit and ORs the
// results. Assumes the relation vector and mask share the same bit order.
module trapcond_decide
    import trapcond_pkg::*;
(
    input  rel_vec_t             rel,
    input  logic [REL_COUNT-1:0] mask,
    output logic                 hit
);

    logic [REL_COUNT-1:0] rel_bits;
    logic [REL_COUNT-1:0] sel_bits;

    // Flatten the struct for per-bit gating.
    always_comb rel_bits = rel;

    generate
        for (genvar k = 0; k < REL_COUNT; k++) begin : g_gate
            // Gate relation k with mask bit k.
            always_comb sel_bits[k] = rel_bits[k] & mask[k];
        end
    endgenerate

    // Any selected relation true raises the hit.
    always_comb hit = |sel_bits;

endmodule

// File: rtl/trapcond_top.sv
// trapcond_top: conditional trap evaluator. Chooses operand B, computes
// five relations, masks them and registers a one-cycle trap request with
// its reason code. Synchronous active-low reset. Assumes the mask is
// 5 bits wide in the order slt, sgt, eq, ult, ugt.
module trapcond_top
    import trapcond_pkg::*;
#(
    parameter int unsigned          DATA_W     = 32,
    parameter int unsigned          IMM_W      = 16,
    parameter int unsigned          REASON_W   = 4,
    parameter logic [REASON_W-1:0]  TRAP_CODE  = 4'd2,
    parameter bit                   SHARED_CMP = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic                 use_imm_i,
    input  logic [DATA_W-1:0]    opa_i,
    input  logic [DATA_W-1:0]    opb_i,
    input  logic [IMM_W-1:0]     imm_i,
    input  logic [REL_COUNT-1:0] cond_mask_i,
    output logic                 trap_o,
    output logic [REASON_W-1:0]  reason_o
);

    logic [DATA_W-1:0]   opnd_b;
    rel_vec_t            rel;
    logic                hit;
    logic                trap_q;
    logic [REASON_W-1:0] reason_q;

    trapcond_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_sel (
        .use_imm (use_imm_i),
        .reg_val (opb_i),
        .imm_val (imm_i),
        .opnd_b  (opnd_b)
    );

    trapcond_relations #(
        .DATA_W     (DATA_W),
        .SHARED_CMP (SHARED_CMP)
    ) u_rel (
        .a   (opa_i),
        .b   (opnd_b),
        .rel (rel)
    );

    trapcond_decide u_dec (
        .rel  (rel),
        .mask (cond_mask_i),
        .hit  (hit)
    );

    // Register the request and its reason; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q   <= 1'b0;
            reason_q <= '0;
        end else begin
            trap_q   <= valid_i && hit;
            reason_q <= (valid_i && hit) ? TRAP_CODE : '0;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        trap_o   = trap_q;
        reason_o = reason_q;
    end

endmodule

// File: rtl/trapcond_chk.sv
// trapcond_chk: temporal checks on the trap evaluator ports, attached
// to trapcond_top by the bind below.
module trapcond_chk #(
    parameter int unsigned          DATA_W    = 32,
    parameter int unsigned          IMM_W     = 16,
    parameter int unsigned          REASON_W  = 4,
    parameter logic [REASON_W-1:0]  TRAP_CODE = 4'd2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_i,
    input logic                use_imm_i,
    input logic [DATA_W-1:0]   opa_i,
    input logic [DATA_W-1:0]   opb_i,
    input logic [IMM_W-1:0]    imm_i,
    input logic [4:0]          cond_mask_i,
    input logic                trap_o,
    input logic [REASON_W-1:0] reason_o
);

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_mask_i == 5'h00) |=> !trap_o); // R7

    AST_MASK_FULL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_mask_i == 5'h1F) |=> trap_o); // R7

    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !trap_o); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!trap_o && reason_o == '0)); // R9

    AST_REASON_WITH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (reason_o == TRAP_CODE)); // R8

    AST_REASON_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> (reason_o == '0)); // R8

    AST_EQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && cond_mask_i == 5'h04 && opa_i == opb_i)
        |=> trap_o); // R3

    AST_SLT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && cond_mask_i == 5'h10
         && $signed(opa_i) < $signed(opb_i)) |=> trap_o); // R1

    AST_ULT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && cond_mask_i == 5'h02 && opa_i < opb_i)
        |=> trap_o); // R4

    AST_IMM_EQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && use_imm_i && cond_mask_i == 5'h04
         && opa_i == {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i}) |=> trap_o); // R6

endmodule

bind trapcond_top trapcond_chk #(
    .DATA_W    (DATA_W),
    .IMM_W     (IMM_W),
    .REASON_W  (REASON_W),
    .TRAP_CODE (TRAP_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .use_imm_i   (use_imm_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .imm_i       (imm_i),
    .cond_mask_i (cond_mask_i),
    .trap_o      (trap_o),
    .reason_o    (reason_o)
);

// File: tb/trapcond_top_tb_top.sv
`timescale 1ns/1ps
module trapcond_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        use_imm_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  cond_mask_i = '0;
    logic        trap_o;
    logic [3:0]  reason_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trapcond_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .use_imm_i   (use_imm_i),
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .imm_i       (imm_i),
        .cond_mask_i (cond_mask_i),
        .trap_o      (trap_o),
        .reason_o    (reason_o)
    );

    // Reference decision from the requirements.
    function automatic bit ref_trap(input logic [31:0] a, input logic [31:0] b,
                                    input logic [15:0] imm, input bit use_imm,
                                    input logic [4:0] m);
        logic [31:0] bb;
        bb = use_imm ? {{16{imm[15]}}, imm} : b;
        return (m[4] && ($signed(a) < $signed(bb))) ||
               (m[3] && ($signed(a) > $signed(bb))) ||
               (m[2] && (a == bb)) ||
               (m[1] && (a < bb)) ||
               (m[0] && (a > bb));
    endfunction

    task automatic check(input bit exp_trap, input string req);
        logic [3:0] exp_rs;
        exp_rs = exp_trap ? 4'd2 : 4'd0;
        checks++;
        if (trap_o !== exp_trap || reason_o !== exp_rs) begin
            errors++;
            $display("FAIL %s: trap=%0b reason=%0d expected trap=%0b reason=%0d",
                     req, trap_o, reason_o, exp_trap, exp_rs);
        end
    endtask

    // Drive one evaluation at a falling edge; check at the next falling edge.
    task automatic eval(input bit v, input bit ui, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] imm,
                        input logic [4:0] m, input string req);
        @(negedge clk);
        valid_i = v; use_imm_i = ui; opa_i = a; opb_i = b; imm_i = imm;
        cond_mask_i = m;
        @(negedge clk);
        check(v && ref_trap(a, b, imm, ui, m), req);
    endtask

    initial begin
        logic [31:0] ra;
        logic [31:0] rb;
        logic [15:0] ri;
        bit          ru;
        bit          rv;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(1'b0, "R9 reset state");
        rst_n = 1'b1;

        // R1/R4: sign-bit extremes, register form
        eval(1, 0, 32'h8000_0000, 32'h1, 16'h0, 5'h10, "R1 slt min vs 1");
        eval(1, 0, 32'h8000_0000, 32'h1, 16'h0, 5'h02, "R4 ult min vs 1");
        eval(1, 0, 32'h8000_0000, 32'h1, 16'h0, 5'h01, "R4 ugt min vs 1");
        eval(1, 0, 32'h8000_0000, 32'h1, 16'h0, 5'h08, "R2 sgt min vs 1");
        eval(1, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'h08, "R2 sgt max vs -1");
        eval(1, 0, 32'h1234_5678, 32'h1234_5678, 16'h0, 5'h04, "R3 equal");
        eval(1, 0, 32'h1234_5678, 32'h1234_5679, 16'h0, 5'h04, "R3 not equal");
        // R6: immediate extension 0xFFFF -> 0xFFFFFFFF
        eval(1, 1, 32'd5, 32'd5, 16'hFFFF, 5'h08, "R6 imm sgt -1");
        eval(1, 1, 32'd5, 32'd5, 16'hFFFF, 5'h02, "R6 imm ult 0xFFFFFFFF");
        eval(1, 1, 32'd5, 32'd5, 16'hFFFF, 5'h01, "R6 imm ugt");
        eval(1, 1, 32'hFFFF_8000, 32'h0, 16'h8000, 5'h04, "R6 imm eq extended");
        // R10: unused operand ignored
        eval(1, 1, 32'd5, 32'd5, 16'd7, 5'h04, "R10 opb ignored in imm form");
        eval(1, 0, 32'd7, 32'd9, 16'd7, 5'h04, "R10 imm ignored in reg form");
        // R7: mask extremes
        eval(1, 0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 16'h0, 5'h00, "R7 zero mask");
        eval(1, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 5'h1F, "R7 full mask equal");
        eval(1, 1, 32'h0, 32'h0, 16'h0001, 5'h1F, "R7 full mask imm");
        // R5: several bits, none true / one true
        eval(1, 0, 32'd10, 32'd10, 16'h0, 5'h1B, "R5 no selected holds");
        eval(1, 0, 32'd10, 32'd20, 16'h0, 5'h0B, "R5 one selected holds");
        // R8: pulse lasts one cycle
        eval(1, 0, 32'd1, 32'd1, 16'h0, 5'h04, "R8 trap cycle");
        eval(0, 0, 32'd1, 32'd1, 16'h0, 5'h04, "R8 drops after one cycle");
        // R9: valid low with hitting inputs
        eval(0, 0, 32'd3, 32'd3, 16'h0, 5'h1F, "R9 valid low");
        // R9: reset wins over a hit
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1; cond_mask_i = 5'h1F;
        @(negedge clk);
        check(1'b0, "R9 reset clears");
        rst_n = 1'b1;

        // Random mix biased toward equality and sign disagreement
        for (int i = 0; i < 3000; i++) begin
            ra = $urandom;
            case ($urandom_range(0, 3))
                0: rb = ra;
                1: rb = ra ^ 32'h8000_0000;
                2: rb = ra + 32'($urandom_range(0, 4)) - 32'd2;
                default: rb = $urandom;
            endcase
            ri = 16'($urandom);
            ru = ($urandom_range(0, 2) == 0);
            if (ru && $urandom_range(0, 3) == 0) ra = {{16{ri[15]}}, ri};
            rv = ($urandom_range(0, 7) != 0);
            eval(rv, ru, ra, rb, ri, 5'($urandom), "R5 random");
        end

        valid_i = 0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule